// File: doc/BRIEF.md
# Delayed-Select Valid Address Detector

This block decides when a bus access is really addressed to the local card. The address decode has two parts. A local comparator matches the low address bits against a fixed offset. An upstream decoder supplies a base-select line that settles some time after the offset bits do. A plain AND of the two can glitch true before and after the real access window. The block therefore masks that skew with a short timer that starts on the access strobe.

The read and write strobes are active low. Both are brought into the fast reference clock domain. When either strobe becomes active, a small counter starts to run. On the edge where the counter reaches its terminal value, the block samples the AND of the offset match and the base select once and holds the result as the access enable. It keeps that enable until both strobes go inactive again. That trailing edge clears the enable and returns the counter to zero. During a read, the local data word is driven onto the bus only while the enable is set and the read strobe is low.

Top module: `dly_sel_addr_qual`

## Requirements
- R1: After reset, `access_en_o` and `bus_oe_o` are 0 and `bus_data_o` is all zeros.
- R2: After a strobe goes low, `access_en_o` stays 0 for the first SYNC_STAGES + 2^(CNT_W-1) - 1 rising clock edges. It is set on edge number SYNC_STAGES + 2^(CNT_W-1) when the address matches and `base_sel_i` is 1 at that edge.
- R3: `access_en_o` takes the value of `base_sel_i` only at the capture edge. A select that is high only before that edge leaves the enable at 0. A select that is low before that edge and high at it sets the enable.
- R4: Once the capture edge has passed, `access_en_o` holds its value while a strobe stays low, whatever `base_sel_i` or the address do afterwards. The counter saturates, so only one capture is made per access.
- R5: The offset match is true only when `addr_i` equals the parameter MATCH_ADDR. On a mismatch, `access_en_o` stays 0.
- R6: The write strobe `wr_n_i` starts the timer and capture in the same way as the read strobe `rd_n_i`. During a write, `bus_oe_o` stays 0.
- R7: When both strobes return high, `access_en_o` clears on rising edge number SYNC_STAGES + 1 after the release.
- R8: A strobe pulse shorter than 2^(CNT_W-1) clock edges makes no capture. A pulse of exactly 2^(CNT_W-1) edges does make a capture.
- R9: `bus_oe_o` equals `access_en_o` AND NOT `rd_n_i`, with `rd_n_i` taken directly without synchronization. `bus_data_o` equals `rd_data_i` when `bus_oe_o` is 1 and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| addr_i | input | ADDR_W | Offset address bits |
| base_sel_i | input | 1 | Delayed base-select from the upstream decoder, active high |
| rd_data_i | input | DATA_W | Word to place on the bus during a read |
| access_en_o | output | 1 | Latched bus-access enable |
| bus_oe_o | output | 1 | Output enable for the read data |
| bus_data_o | output | DATA_W | Gated read data |

## Verification
The bench uses the default build: two synchronizer stages, a 2-bit counter, a 15-bit offset and a 32-bit data word. With this build the capture edge falls on the fourth clock edge after the strobe, so exact edge counts can be checked directly.

The bench sweeps every combination of:
- strobe type (read or write),
- offset hit or miss,
- select level before the capture edge,
- select level at the capture edge.

It also probes both sides of the minimum pulse length with one-edge and two-edge strobe pulses.

// File: rtl/dsaq_pkg.sv
package dsaq_pkg;
   // Number of increments the settle counter needs before its top bit sets
   function automatic int unsigned settle_edges(input int unsigned cnt_w);
      return 32'd1 << (cnt_w - 1);
   endfunction
endpackage

// File: rtl/dsaq_strobe_sync.sv
module dsaq_strobe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic rd_n_i,
   input  logic wr_n_i,
   output logic rd_n_s_o,
   output logic wr_n_s_o,
   output logic active_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign rd_n_s_o = rd_n_i;
         assign wr_n_s_o = wr_n_i;
      end else begin : g_chain
         logic [STAGES-1:0] rd_q;
         logic [STAGES-1:0] wr_q;
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
               rd_q <= '1;
               wr_q <= '1;
            end else begin
               rd_q <= {rd_q[STAGES-2+((STAGES==1)?1:0):0], rd_n_i};
               wr_q <= {wr_q[STAGES-2+((STAGES==1)?1:0):0], wr_n_i};
            end
         end
         assign rd_n_s_o = rd_q[STAGES-1];
         assign wr_n_s_o = wr_q[STAGES-1];
      end
   endgenerate

   assign active_o = ~rd_n_s_o | ~wr_n_s_o;
endmodule

// File: rtl/dsaq_settle_timer.sv
module dsaq_settle_timer
   import dsaq_pkg::*;
#(
   parameter int unsigned CNT_W = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic active_i,
   output logic done_o,
   output logic capture_o
);
   localparam int unsigned        HALF    = settle_edges(CNT_W);
   localparam logic [CNT_W-1:0]   LAST_LO = CNT_W'(HALF - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)               cnt_q <= '0;
      else if (!active_i)         cnt_q <= '0;
      else if (!cnt_q[CNT_W-1])   cnt_q <= cnt_q + 1'b1;
   end

   assign done_o    = cnt_q[CNT_W-1];
   assign capture_o = active_i && (cnt_q == LAST_LO);

   p_sat_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (done_o && active_i) |=> done_o);
   p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !active_i |=> (cnt_q == '0));
   p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (active_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dsaq_offset_match.sv
module dsaq_offset_match #(
   parameter int unsigned           ADDR_W     = 15,
   parameter logic [ADDR_W-1:0]     MATCH_ADDR = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   assign hit_o = (addr_i == MATCH_ADDR);
endmodule

// File: rtl/dly_sel_addr_qual.sv
module dly_sel_addr_qual #(
   parameter int unsigned        SYNC_STAGES = 2,
   parameter int unsigned        CNT_W       = 2,
   parameter int unsigned        ADDR_W      = 15,
   parameter int unsigned        DATA_W      = 32,
   parameter logic [ADDR_W-1:0]  MATCH_ADDR  = 15'h0A5C
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              base_sel_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              access_en_o,
   output logic              bus_oe_o,
   output logic [DATA_W-1:0] bus_data_o
);
   generate
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
         $error("CNT_W must lie in 1..8");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic rd_n_s, wr_n_s, active;
   logic done, capture, hit;
   logic en_q;

   dsaq_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .rd_n_i  (rd_n_i),
      .wr_n_i  (wr_n_i),
      .rd_n_s_o(rd_n_s),
      .wr_n_s_o(wr_n_s),
      .active_o(active)
   );

   dsaq_settle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .active_i (active),
      .done_o   (done),
      .capture_o(capture)
   );

   dsaq_offset_match #(.ADDR_W(ADDR_W), .MATCH_ADDR(MATCH_ADDR)) u_match (
      .addr_i(addr_i),
      .hit_o (hit)
   );

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)      en_q <= 1'b0;
      else if (!active)  en_q <= 1'b0;
      else if (capture)  en_q <= hit & base_sel_i;
   end

   assign access_en_o = en_q;
   assign bus_oe_o    = en_q & ~rd_n_i;
   assign bus_data_o  = bus_oe_o ? rd_data_i : '0;

   p_rise_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(en_q) |-> ($past(hit && base_sel_i) && done));
   p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (en_q && active) |=> en_q);
   p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !active |=> !en_q);
   p_no_early_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!done && !capture) |=> !$rose(en_q));
   always_comb begin
      if (rst_n_i) begin
         p_oe_gate_r9: assert (!bus_oe_o || (en_q && !rd_n_i));
         p_data_zero_r9: assert (bus_oe_o || bus_data_o == '0);
      end
   end
   p_write_no_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      rd_n_i |-> !bus_oe_o);
endmodule

// File: tb/dly_sel_addr_qual_tb_top.sv
module dly_sel_addr_qual_tb_top;
   localparam int unsigned SYNC  = 2;
   localparam int unsigned CW    = 2;
   localparam int unsigned HALFE = 1 << (CW - 1);
   localparam int unsigned LAT   = SYNC + HALFE;
   localparam logic [14:0] MADDR = 15'h0A5C;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        rd_n = 1, wr_n = 1, base_sel = 0;
   logic [14:0] addr = '0;
   logic [31:0] rdata = '0;
   logic        en, oe;
   logic [31:0] bdata;
   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   dly_sel_addr_qual #(.SYNC_STAGES(SYNC), .CNT_W(CW), .ADDR_W(15),
                       .DATA_W(32), .MATCH_ADDR(MADDR)) dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
      .addr_i(addr), .base_sel_i(base_sel), .rd_data_i(rdata),
      .access_en_o(en), .bus_oe_o(oe), .bus_data_o(bdata));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_access(input bit is_rd, input bit hit, input bit sel_pre, input bit sel_cap);
      bit exp;
      exp = hit & sel_cap;
      @(negedge clk);
      addr = hit ? MADDR : (MADDR ^ 15'h0001);
      base_sel = sel_pre;
      rdata = {16'hC0DE, 13'h0, is_rd, sel_pre, sel_cap};
      rd_n = !is_rd;
      wr_n = is_rd;
      for (int i = 0; i < int'(LAT) - 1; i++) @(negedge clk);
      chk("R2 no early enable", {31'b0, en}, 32'd0);
      base_sel = sel_cap;
      @(negedge clk);
      chk(hit ? "R3 capture level" : "R5 mismatch", {31'b0, en}, {31'b0, exp});
      chk(is_rd ? "R9 oe on read" : "R6 no oe on write", {31'b0, oe}, {31'b0, exp & is_rd});
      chk("R9 data gate", bdata, (exp & is_rd) ? rdata : 32'd0);
      base_sel = ~sel_cap;
      addr = ~addr;
      repeat (3) @(negedge clk);
      chk("R4 hold after capture", {31'b0, en}, {31'b0, exp});
      rd_n = 1;
      wr_n = 1;
      #1;
      chk("R9 oe drops with raw strobe", {31'b0, oe}, 32'd0);
      for (int i = 0; i < int'(SYNC); i++) @(negedge clk);
      chk("R7 still set before clear edge", {31'b0, en}, {31'b0, exp});
      @(negedge clk);
      chk("R7 cleared", {31'b0, en}, 32'd0);
      base_sel = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse(input int unsigned len, input bit exp);
      @(negedge clk);
      addr = MADDR;
      base_sel = 1;
      rd_n = 0;
      for (int i = 0; i < int'(len); i++) @(negedge clk);
      rd_n = 1;
      for (int i = int'(len); i < int'(LAT); i++) @(negedge clk);
      chk("R8 pulse length", {31'b0, en}, {31'b0, exp});
      repeat (SYNC + 3) @(negedge clk);
      chk("R8 pulse cleared", {31'b0, en}, 32'd0);
      base_sel = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 enable reset", {31'b0, en}, 32'd0);
      chk("R1 oe reset", {31'b0, oe}, 32'd0);
      chk("R1 data reset", bdata, 32'd0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 16; k++)
         run_access(k[3], k[2], k[1], k[0]);
      pulse(HALFE - 1, 1'b0);
      pulse(HALFE, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule